// File: doc/BRIEF.md
# Range Partition Selector

This block sits at the entry of a multi-chip ternary-match lookup system. For every 32-bit IPv4 destination address it reports the bucket whose address range holds the address. It also reports which physical chip holds that bucket and which partition inside the chip it uses. Only that one partition then needs to be searched, so the other partitions stay idle.

Each bucket owns an inclusive low and high boundary register. The address is compared against all pairs at once. The match vector is encoded to a bucket number, and a small index table turns that number into a chip and a partition. Software loads boundaries and table entries through a single write port. The pipeline accepts one address per clock and has a fixed latency.

Top module: `bucket_range_sel`

## Requirements
- R1: A request presented with `req_valid_i` high in cycle n produces a response with `rsp_valid_o` high in cycle n+3, with one response per request under back-to-back traffic.
- R2: A bucket matches when low <= address <= high, with both bounds inclusive, and the reported bucket is a matching bucket.
- R3: After reset, bucket i covers [i*2^27, (i+1)*2^27-1], so bucket 0 starts at all zeros and bucket 31 ends at all ones.
- R4: When several buckets match, the lowest-numbered one is reported.
- R5: When no bucket matches, `rsp_err_o` is 1, `rsp_bucket_o` is 0, and the chip and partition are those of index entry 0.
- R6: A write with `cfg_sel_i`=0 loads bucket `cfg_idx_i`'s low bound and 1 loads its high bound. The new value applies to addresses presented in the cycle after the write, and not to an address presented in the same cycle.
- R7: A write with `cfg_sel_i`=2 loads index entry `cfg_idx_i`, where `cfg_data_i`[4:3] is the chip and [2:0] is the partition. After reset, entry i holds chip i/8 and partition i%8.
- R8: For a split prefix P, setting bucket u's high bound to P·0…0 − 1 and bucket u+1's low bound to P·0…0 sends P·0…0 to u+1 and the address just below it to u.
- R9: In a cycle with no response, `rsp_valid_o` and `rsp_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Address valid |
| req_addr_i | input | 32 | Destination address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | 0 low bound, 1 high bound, 2 index entry, 3 none |
| cfg_idx_i | input | 5 | Bucket number being written |
| cfg_data_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_bucket_o | output | 5 | Selected bucket |
| rsp_chip_o | output | 2 | Chip holding the bucket |
| rsp_part_o | output | 3 | Partition in that chip |
| rsp_err_o | output | 1 | No bucket matched |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 32 buckets and 4 chips of 8 partitions. With these values the reset ranges are 2^27-wide slices whose edges fall on easily written addresses. Every bucket number maps to a distinct chip and partition pair, so an index-table slip shows up at the ports. The 5-bit bucket field also brings both ends of the address space, overlapping ranges, a deliberate gap and a prefix split within reach of short directed sequences.

// File: rtl/bkt_sel_pkg.sv
package bkt_sel_pkg;
  typedef enum logic [1:0] {
    CFG_LOW  = 2'd0,
    CFG_HIGH = 2'd1,
    CFG_MAP  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/bkt_bound_regs.sv
module bkt_bound_regs
  import bkt_sel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_BKT = 32,
  parameter int BKT_W   = $clog2(NUM_BKT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  cfg_sel_e          sel_i,
  input  logic [BKT_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] low_o  [NUM_BKT],
  output logic [ADDR_W-1:0] high_o [NUM_BKT]
);
  localparam int SHIFT = ADDR_W - BKT_W;
  localparam logic [ADDR_W-1:0] SPAN_M1 = {ADDR_W{1'b1}} >> BKT_W;

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_bkt
    localparam logic [ADDR_W-1:0] RST_LO = ADDR_W'(i) << SHIFT;
    logic sel_me;
    assign sel_me = we_i && (idx_i == BKT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        low_o[i]  <= RST_LO;
        high_o[i] <= RST_LO | SPAN_M1;
      end else if (sel_me) begin
        if (sel_i == CFG_LOW)  low_o[i]  <= data_i;
        if (sel_i == CFG_HIGH) high_o[i] <= data_i;
      end
    end
  end
endmodule

// File: rtl/bkt_cmp_stage.sv
module bkt_cmp_stage #(
  parameter int ADDR_W  = 32,
  parameter int NUM_BKT = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  low_i  [NUM_BKT],
  input  logic [ADDR_W-1:0]  high_i [NUM_BKT],
  output logic               vld_q_o,
  output logic [NUM_BKT-1:0] hit_q_o
);
  logic [NUM_BKT-1:0] hit_d;

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_cmp
    assign hit_d[i] = (addr_i >= low_i[i]) && (addr_i <= high_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q_o <= 1'b0;
      hit_q_o <= '0;
    end else begin
      vld_q_o <= vld_i;
      hit_q_o <= vld_i ? hit_d : '0;
    end
  end
endmodule

// File: rtl/bkt_enc_stage.sv
module bkt_enc_stage #(
  parameter int NUM_BKT = 32,
  parameter int BKT_W   = $clog2(NUM_BKT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [NUM_BKT-1:0] hit_i,
  output logic               vld_q_o,
  output logic               err_q_o,
  output logic [BKT_W-1:0]   bkt_q_o
);
  logic [BKT_W-1:0] bkt_d;

  // lowest index wins
  always_comb begin
    bkt_d = '0;
    for (int i = NUM_BKT - 1; i >= 0; i--) begin
      if (hit_i[i]) bkt_d = BKT_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q_o <= 1'b0;
      err_q_o <= 1'b0;
      bkt_q_o <= '0;
    end else begin
      vld_q_o <= vld_i;
      err_q_o <= vld_i && (hit_i == '0);
      bkt_q_o <= bkt_d;
    end
  end
endmodule

// File: rtl/bkt_map_table.sv
module bkt_map_table
  import bkt_sel_pkg::*;
#(
  parameter int NUM_BKT = 32,
  parameter int BKT_W   = $clog2(NUM_BKT),
  parameter int CHIP_W  = 2,
  parameter int PART_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  cfg_sel_e                 sel_i,
  input  logic [BKT_W-1:0]         idx_i,
  input  logic [CHIP_W+PART_W-1:0] data_i,
  input  logic                     vld_i,
  input  logic                     err_i,
  input  logic [BKT_W-1:0]         bkt_i,
  output logic                     vld_o,
  output logic                     err_o,
  output logic [BKT_W-1:0]         bkt_o,
  output logic [CHIP_W-1:0]        chip_o,
  output logic [PART_W-1:0]        part_o
);
  localparam int ENT_W = CHIP_W + PART_W;
  localparam int PPC   = 1 << PART_W;

  logic [ENT_W-1:0] tbl [NUM_BKT];

  for (genvar i = 0; i < NUM_BKT; i++) begin : g_ent
    localparam logic [ENT_W-1:0] RST_ENT = {CHIP_W'(i / PPC), PART_W'(i % PPC)};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tbl[i] <= RST_ENT;
      else if (we_i && sel_i == CFG_MAP && idx_i == BKT_W'(i))
        tbl[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      bkt_o  <= '0;
      chip_o <= '0;
      part_o <= '0;
    end else begin
      vld_o  <= vld_i;
      err_o  <= err_i;
      bkt_o  <= bkt_i;
      {chip_o, part_o} <= tbl[bkt_i];
    end
  end
endmodule

// File: rtl/bucket_range_sel.sv
module bucket_range_sel
  import bkt_sel_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKT  = 32,
  parameter int NUM_CHIP = 4,
  localparam int BKT_W   = $clog2(NUM_BKT),
  localparam int CHIP_W  = $clog2(NUM_CHIP),
  localparam int PART_W  = $clog2(NUM_BKT / NUM_CHIP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [BKT_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  output logic              rsp_valid_o,
  output logic [BKT_W-1:0]  rsp_bucket_o,
  output logic [CHIP_W-1:0] rsp_chip_o,
  output logic [PART_W-1:0] rsp_part_o,
  output logic              rsp_err_o
);
  cfg_sel_e           cfg_sel;
  logic [ADDR_W-1:0]  low_b  [NUM_BKT];
  logic [ADDR_W-1:0]  high_b [NUM_BKT];
  logic               cmp_vld;
  logic [NUM_BKT-1:0] cmp_hit;
  logic               enc_vld;
  logic               enc_err;
  logic [BKT_W-1:0]   enc_bkt;

  assign cfg_sel = cfg_sel_e'(cfg_sel_i);

  bkt_bound_regs #(.ADDR_W(ADDR_W), .NUM_BKT(NUM_BKT), .BKT_W(BKT_W)) u_bounds (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel), .idx_i(cfg_idx_i), .data_i(cfg_data_i),
    .low_o(low_b), .high_o(high_b)
  );

  bkt_cmp_stage #(.ADDR_W(ADDR_W), .NUM_BKT(NUM_BKT)) u_cmp (
    .clk_i, .rst_ni,
    .vld_i(req_valid_i), .addr_i(req_addr_i),
    .low_i(low_b), .high_i(high_b),
    .vld_q_o(cmp_vld), .hit_q_o(cmp_hit)
  );

  bkt_enc_stage #(.NUM_BKT(NUM_BKT), .BKT_W(BKT_W)) u_enc (
    .clk_i, .rst_ni,
    .vld_i(cmp_vld), .hit_i(cmp_hit),
    .vld_q_o(enc_vld), .err_q_o(enc_err), .bkt_q_o(enc_bkt)
  );

  bkt_map_table #(.NUM_BKT(NUM_BKT), .BKT_W(BKT_W), .CHIP_W(CHIP_W), .PART_W(PART_W)) u_map (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel), .idx_i(cfg_idx_i),
    .data_i(cfg_data_i[CHIP_W+PART_W-1:0]),
    .vld_i(enc_vld), .err_i(enc_err), .bkt_i(enc_bkt),
    .vld_o(rsp_valid_o), .err_o(rsp_err_o), .bkt_o(rsp_bucket_o),
    .chip_o(rsp_chip_o), .part_o(rsp_part_o)
  );
endmodule

// File: rtl/bkt_sel_chk.sv
module bkt_sel_chk #(
  parameter int NUM_BKT = 32,
  parameter int BKT_W   = $clog2(NUM_BKT)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               rsp_valid_o,
  input logic               rsp_err_o,
  input logic [BKT_W-1:0]   rsp_bucket_o,
  input logic [NUM_BKT-1:0] cmp_hit,
  input logic               enc_vld,
  input logic               enc_err,
  input logic [BKT_W-1:0]   enc_bkt
);
  logic [1:0]         age;
  logic [NUM_BKT-1:0] hit_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age   <= '0;
      hit_d <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      hit_d <= cmp_hit;
    end
  end

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (rsp_valid_o == $past(req_valid_i, 3)));

  p_hit_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_vld && !enc_err) |-> hit_d[enc_bkt]);

  p_lowest_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_vld && !enc_err) |-> ((hit_d & ((NUM_BKT'(1) << enc_bkt) - NUM_BKT'(1))) == '0));

  p_miss_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_err |-> (hit_d == '0 && enc_bkt == '0));

  p_err_bucket0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_bucket_o == '0));

  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);
endmodule

bind bucket_range_sel bkt_sel_chk #(.NUM_BKT(NUM_BKT), .BKT_W(BKT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_bucket_o(rsp_bucket_o),
  .cmp_hit(cmp_hit), .enc_vld(enc_vld), .enc_err(enc_err), .enc_bkt(enc_bkt)
);

// File: tb/bucket_range_sel_bench.sv
module bucket_range_sel_bench;
  localparam int NV = 8;
  // {address, expected bucket} under the reset ranges (R3)
  localparam logic [36:0] VEC [NV] = '{
    {32'h0000_0000, 5'd0},  {32'h07FF_FFFF, 5'd0},
    {32'h0800_0000, 5'd1},  {32'h5A5A_1234, 5'd11},
    {32'h7FFF_FFFF, 5'd15}, {32'h8000_0000, 5'd16},
    {32'hC0A8_0101, 5'd24}, {32'hFFFF_FFFF, 5'd31}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd3;
  logic [4:0]  cfg_idx_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [4:0]  rsp_bucket_o;
  logic [1:0]  rsp_chip_o;
  logic [2:0]  rsp_part_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bucket_range_sel u_bucket_range_sel (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_rsp(input string tag, input logic [4:0] b, input logic err,
                           input logic [1:0] chip, input logic [2:0] part);
    chk({tag, " valid"}, 32'(rsp_valid_o), 32'd1);
    chk({tag, " bucket"}, 32'(rsp_bucket_o), 32'(b));
    chk({tag, " err"}, 32'(rsp_err_o), 32'(err));
    chk({tag, " chip"}, 32'(rsp_chip_o), 32'(chip));
    chk({tag, " part"}, 32'(rsp_part_o), 32'(part));
  endtask

  // reset mapping of R7
  function automatic logic [1:0] dchip(input logic [4:0] b); return b[4:3]; endfunction
  function automatic logic [2:0] dpart(input logic [4:0] b); return b[2:0]; endfunction

  task automatic cfg(input logic [1:0] sel, input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = idx; cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_sel_i = 2'd3;
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [4:0] b,
                      input logic err, input logic [1:0] chip, input logic [2:0] part);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check_rsp(tag, b, err, chip, part);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", 32'(rsp_valid_o), 32'd0);
    chk("R9 reset err", 32'(rsp_err_o), 32'd0);
    rst_ni = 1'b1;

    // R3/R2/R7: reset ranges and reset index table
    for (int i = 0; i < NV; i++) begin
      logic [4:0] b;
      b = VEC[i][4:0];
      look("R3", VEC[i][36:5], b, 1'b0, dchip(b), dpart(b));
    end

    // R1: back-to-back stream, response three cycles after each request
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk_i);
      if (j >= 3) begin
        logic [4:0] b;
        b = VEC[j-3][4:0];
        check_rsp("R1 stream", b, 1'b0, dchip(b), dpart(b));
      end else begin
        chk("R1 fill", 32'(rsp_valid_o), 32'd0);
      end
      req_valid_i = (j < NV);
      req_addr_i  = (j < NV) ? VEC[j][36:5] : '0;
    end
    @(negedge clk_i);
    chk("R9 idle valid", 32'(rsp_valid_o), 32'd0);
    chk("R9 idle err", 32'(rsp_err_o), 32'd0);

    // R6 + R4: write bucket 0 high in the same cycle as a request
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 2'd1; cfg_idx_i = 5'd0; cfg_data_i = 32'h0FFF_FFFF;
    req_valid_i = 1'b1; req_addr_i = 32'h0900_0000;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_sel_i = 2'd3;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check_rsp("R6 same-cycle old bound", 5'd1, 1'b0, 2'd0, 3'd1);
    @(negedge clk_i);
    check_rsp("R4 overlap lowest wins", 5'd0, 1'b0, 2'd0, 3'd0);

    // R8: split at prefix 0x0A/8
    cfg(2'd1, 5'd0, 32'h09FF_FFFF);
    cfg(2'd0, 5'd1, 32'h0A00_0000);
    look("R8 below split", 32'h09FF_FFFF, 5'd0, 1'b0, 2'd0, 3'd0);
    look("R8 at split", 32'h0A00_0000, 5'd1, 1'b0, 2'd0, 3'd1);
    look("R2 high inclusive", 32'h0FFF_FFFF, 5'd1, 1'b0, 2'd0, 3'd1);

    // R5: open a gap in bucket 3
    cfg(2'd0, 5'd3, 32'h1900_0000);
    look("R5 gap", 32'h1800_0000, 5'd0, 1'b1, 2'd0, 3'd0);
    look("R2 low inclusive", 32'h1900_0000, 5'd3, 1'b0, 2'd0, 3'd3);

    // R7: remap bucket 31 to chip 1 partition 7
    cfg(2'd2, 5'd31, 32'd15);
    look("R7 remap", 32'hFFFF_FFFF, 5'd31, 1'b0, 2'd1, 3'd7);
    look("R7 other entry", 32'hF000_0000, 5'd30, 1'b0, 2'd3, 3'd6);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule